// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller

This block runs automatic software flow control for one serial channel, in both directions. On the local receive path it compares the receive FIFO fill level with two programmable thresholds. It asks the transmitter to insert an Xoff character when the FIFO is getting full. It asks for an Xon character once the FIFO has drained, but only if an Xoff went out earlier. The transmitter inserts the requested character ahead of any queued data byte. It does so even when the modem clear-to-send line or a remote pause would hold data back.

On the remote direction the block inspects every character delivered by the receive shifter. A received Xoff code pauses the local transmitter and a received Xon code resumes it. The transmitter applies the pause at its next character boundary. Flow codes that are recognised are consumed here and never reach the receive FIFO; all other characters are passed on one cycle later. The current flow state can be read by the host: whether an Xoff is outstanding toward the far end, and whether the far end has paused this transmitter.

The two code values, both thresholds and the two direction enables come from configuration registers held outside the block. The block does not contain the shift registers or the FIFOs.

Top module: `flow_xon_ctrl`

## Requirements
- R1: After reset, tx_pause, st_xoff_sent, tx_ins_req and rx_wr are all 0.
- R2: With cfg_send_en high, no Xoff outstanding and no request pending, a rx_fill at or above cfg_hi_level raises tx_ins_req one cycle later with tx_ins_char equal to cfg_xoff_char. This holds across the whole threshold range, including a threshold equal to the FIFO depth.
- R3: tx_ins_req and tx_ins_char hold steady until a cycle with tx_ins_ack high. tx_ins_req then drops on the next cycle, and if the character was the Xoff code, st_xoff_sent goes to 1.
- R4: While st_xoff_sent is 1, a fill level that stays at or above cfg_hi_level raises no further request, so Xoff is sent once.
- R5: With st_xoff_sent at 1, a rx_fill at or below cfg_lo_level raises tx_ins_req one cycle later with tx_ins_char equal to cfg_xon_char. With st_xoff_sent at 0, a low fill level raises no request.
- R6: An acknowledged Xon insertion clears st_xoff_sent on the next cycle.
- R7: With cfg_obey_en high, a rx_valid cycle carrying cfg_xoff_char sets tx_pause on the next cycle, and rx_wr stays 0 for that character.
- R8: With cfg_obey_en high, a rx_valid cycle carrying cfg_xon_char clears tx_pause on the next cycle, and rx_wr stays 0 for that character.
- R9: Any other received character is passed on: rx_wr is 1 for exactly one cycle, one cycle after rx_valid, with rx_wr_char equal to the character. With cfg_obey_en low, flow codes are passed on the same way, and tx_pause is 0 from the cycle after cfg_obey_en is seen low.
- R10: tx_data_ok, which allows the transmitter to load the next FIFO byte, is 1 only when cts_ok is 1, tx_pause is 0 and no insertion is pending. tx_ins_req itself is raised regardless of cts_ok and tx_pause.
- R11: With cfg_send_en low, no new insertion request is raised at any fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_send_en | input | 1 | Enable sending Xon/Xoff from receive fill level |
| cfg_obey_en | input | 1 | Enable obeying received Xon/Xoff codes |
| cfg_xon_char | input | 8 | Xon code value |
| cfg_xoff_char | input | 8 | Xoff code value |
| cfg_hi_level | input | LVL_W (8) | Fill level at which Xoff is requested |
| cfg_lo_level | input | LVL_W (8) | Fill level at which Xon is requested |
| rx_fill | input | LVL_W (8) | Current receive FIFO fill level |
| rx_valid | input | 1 | Strobe: a received character is on rx_char |
| rx_char | input | 8 | Received character from the shifter |
| rx_wr | output | 1 | Write strobe toward the receive FIFO |
| rx_wr_char | output | 8 | Character to write into the receive FIFO |
| tx_ins_req | output | 1 | Request to insert a flow character |
| tx_ins_char | output | 8 | Flow character to insert |
| tx_ins_ack | input | 1 | Transmitter has taken the flow character |
| cts_ok | input | 1 | Modem clear-to-send, 1 = clear |
| tx_pause | output | 1 | Remote end has paused this transmitter (readable) |
| tx_data_ok | output | 1 | Transmitter may load the next FIFO data byte |
| st_xoff_sent | output | 1 | An Xoff is outstanding toward the remote end (readable) |

## Verification
The assertions assume three things about the inputs:
- The code values, thresholds and enables stay still while an insertion request is pending.
- tx_ins_ack is only raised while tx_ins_req is high.
- Xon and Xoff are programmed to different codes.

The bench changes configuration only when no request is outstanding. It raises the acknowledge only after it has seen the request. It uses the distinct codes 0x11 and 0x13 throughout.

// File: rtl/flow_xon_pkg.sv
package flow_xon_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic {
        INS_XON  = 1'b0,
        INS_XOFF = 1'b1
    } ins_kind_e;

    typedef struct packed {
        logic      req;
        ins_kind_e kind;
        logic      xoff_sent;
    } send_state_t;

    typedef struct packed {
        logic              paused;
        logic              wr;
        logic [CHAR_W-1:0] data;
    } recv_state_t;

endpackage

// File: rtl/flow_char_match.sv
module flow_char_match
    import flow_xon_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    output logic              hit_xon,
    output logic              hit_xoff
);

    // Per-bit equality, reduced at the end.
    logic [CHAR_W-1:0] eq_on;
    logic [CHAR_W-1:0] eq_off;

    for (genvar b = 0; b < CHAR_W; b++) begin : g_bit
        assign eq_on[b]  = ~(char_in[b] ^ xon_code[b]);
        assign eq_off[b] = ~(char_in[b] ^ xoff_code[b]);
    end

    assign hit_xon  = &eq_on;
    assign hit_xoff = &eq_off;

endmodule

// File: rtl/flow_rx_side.sv
module flow_rx_side
    import flow_xon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obey_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    output logic              paused,
    output logic              wr,
    output logic [CHAR_W-1:0] wr_data
);

    recv_state_t state_d, state_q;
    logic        is_xon, is_xoff;

    flow_char_match u_match (
        .char_in   (rx_char),
        .xon_code  (xon_code),
        .xoff_code (xoff_code),
        .hit_xon   (is_xon),
        .hit_xoff  (is_xoff)
    );

    always_comb begin
        state_d    = state_q;
        state_d.wr = 1'b0;
        if (!obey_en) begin
            state_d.paused = 1'b0;
        end
        if (rx_valid) begin
            if (obey_en && is_xoff) begin
                state_d.paused = 1'b1;
            end else if (obey_en && is_xon) begin
                state_d.paused = 1'b0;
            end else begin
                state_d.wr   = 1'b1;
                state_d.data = rx_char;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign paused  = state_q.paused;
    assign wr      = state_q.wr;
    assign wr_data = state_q.data;

endmodule

// File: rtl/flow_tx_side.sv
module flow_tx_side
    import flow_xon_pkg::*;
#(
    parameter int unsigned LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_en,
    input  logic [LVL_W-1:0]  fill,
    input  logic [LVL_W-1:0]  hi_level,
    input  logic [LVL_W-1:0]  lo_level,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    input  logic              ack,
    output logic              req,
    output logic [CHAR_W-1:0] ins_char,
    output logic              xoff_sent
);

    send_state_t state_d, state_q;
    logic        at_high, at_low;

    assign at_high = (fill >= hi_level);
    assign at_low  = (fill <= lo_level);

    always_comb begin
        state_d = state_q;
        if (state_q.req) begin
            // Request is held until the transmitter takes it.
            if (ack) begin
                state_d.req       = 1'b0;
                state_d.xoff_sent = (state_q.kind == INS_XOFF);
            end
        end else if (send_en) begin
            if (!state_q.xoff_sent && at_high) begin
                state_d.req  = 1'b1;
                state_d.kind = INS_XOFF;
            end else if (state_q.xoff_sent && at_low) begin
                state_d.req  = 1'b1;
                state_d.kind = INS_XON;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{req: 1'b0, kind: INS_XON, xoff_sent: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign req       = state_q.req;
    assign ins_char  = (state_q.kind == INS_XOFF) ? xoff_code : xon_code;
    assign xoff_sent = state_q.xoff_sent;

endmodule

// File: rtl/flow_xon_ctrl.sv
module flow_xon_ctrl
    import flow_xon_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_send_en,
    input  logic              cfg_obey_en,
    input  logic [CHAR_W-1:0] cfg_xon_char,
    input  logic [CHAR_W-1:0] cfg_xoff_char,
    input  logic [LVL_W-1:0]  cfg_hi_level,
    input  logic [LVL_W-1:0]  cfg_lo_level,
    input  logic [LVL_W-1:0]  rx_fill,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_wr,
    output logic [CHAR_W-1:0] rx_wr_char,
    output logic              tx_ins_req,
    output logic [CHAR_W-1:0] tx_ins_char,
    input  logic              tx_ins_ack,
    input  logic              cts_ok,
    output logic              tx_pause,
    output logic              tx_data_ok,
    output logic              st_xoff_sent
);

    flow_rx_side u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .obey_en   (cfg_obey_en),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .xon_code  (cfg_xon_char),
        .xoff_code (cfg_xoff_char),
        .paused    (tx_pause),
        .wr        (rx_wr),
        .wr_data   (rx_wr_char)
    );

    flow_tx_side #(
        .LVL_W (LVL_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_en   (cfg_send_en),
        .fill      (rx_fill),
        .hi_level  (cfg_hi_level),
        .lo_level  (cfg_lo_level),
        .xon_code  (cfg_xon_char),
        .xoff_code (cfg_xoff_char),
        .ack       (tx_ins_ack),
        .req       (tx_ins_req),
        .ins_char  (tx_ins_char),
        .xoff_sent (st_xoff_sent)
    );

    // A pending flow character wins over the next data byte.
    // The insertion itself ignores cts_ok and tx_pause.
    assign tx_data_ok = cts_ok && !tx_pause && !tx_ins_req;

endmodule

// File: rtl/flow_xon_checker.sv
module flow_xon_checker
    import flow_xon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_send_en,
    input logic              cfg_obey_en,
    input logic [CHAR_W-1:0] cfg_xon_char,
    input logic [CHAR_W-1:0] cfg_xoff_char,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic              rx_wr,
    input logic              tx_ins_req,
    input logic [CHAR_W-1:0] tx_ins_char,
    input logic              tx_ins_ack,
    input logic              tx_pause,
    input logic              tx_data_ok,
    input logic              st_xoff_sent
);

    // R3: the request and its character are held until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ins_req && !tx_ins_ack |=> tx_ins_req && $stable(tx_ins_char));

    // R3: an acknowledge retires the request
    p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ins_req && tx_ins_ack |=> !tx_ins_req);

    // R3: the Xoff-outstanding flag only rises through an acknowledged insertion
    p_xoff_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_xoff_sent) |-> $past(tx_ins_req && tx_ins_ack));

    // R6: the flag only falls through an acknowledged insertion
    p_xoff_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_xoff_sent) |-> $past(tx_ins_req && tx_ins_ack));

    // R5: a new Xon request only appears while an Xoff is outstanding
    p_xon_needs_xoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ins_req) && (tx_ins_char == cfg_xon_char) |-> st_xoff_sent);

    // R11: no new request without the send enable
    p_req_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ins_req) |-> $past(cfg_send_en));

    // R7: a received Xoff code pauses and is not stored
    p_xoff_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && cfg_obey_en && (rx_char == cfg_xoff_char) |=> tx_pause && !rx_wr);

    // R8: a received Xon code resumes and is not stored
    p_xon_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && cfg_obey_en && (rx_char == cfg_xon_char)
        && (cfg_xon_char != cfg_xoff_char) |=> !tx_pause && !rx_wr);

    // R9: with obeying off, the pause is released
    p_pause_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_obey_en |=> !tx_pause);

    // R9: a store strobe only follows a received character
    p_wr_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> $past(rx_valid));

    // R10: data loading is blocked while a flow character is pending or paused
    p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ins_req || tx_pause) |-> !tx_data_ok);

endmodule

bind flow_xon_ctrl flow_xon_checker u_flow_xon_checker (.*);

// File: tb/test_flow_xon_ctrl.sv
module test_flow_xon_ctrl;

    localparam int unsigned LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_send_en, cfg_obey_en;
    logic [7:0]       cfg_xon_char, cfg_xoff_char;
    logic [LVL_W-1:0] cfg_hi_level, cfg_lo_level, rx_fill;
    logic             rx_valid;
    logic [7:0]       rx_char;
    logic             rx_wr;
    logic [7:0]       rx_wr_char;
    logic             tx_ins_req;
    logic [7:0]       tx_ins_char;
    logic             tx_ins_ack, cts_ok;
    logic             tx_pause, tx_data_ok, st_xoff_sent;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flow_xon_ctrl i_flow_xon_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_send_en   (cfg_send_en),
        .cfg_obey_en   (cfg_obey_en),
        .cfg_xon_char  (cfg_xon_char),
        .cfg_xoff_char (cfg_xoff_char),
        .cfg_hi_level  (cfg_hi_level),
        .cfg_lo_level  (cfg_lo_level),
        .rx_fill       (rx_fill),
        .rx_valid      (rx_valid),
        .rx_char       (rx_char),
        .rx_wr         (rx_wr),
        .rx_wr_char    (rx_wr_char),
        .tx_ins_req    (tx_ins_req),
        .tx_ins_char   (tx_ins_char),
        .tx_ins_ack    (tx_ins_ack),
        .cts_ok        (cts_ok),
        .tx_pause      (tx_pause),
        .tx_data_ok    (tx_data_ok),
        .st_xoff_sent  (st_xoff_sent)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack();
        tx_ins_ack = 1'b1;
        step();
        tx_ins_ack = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] c);
        rx_valid = 1'b1;
        rx_char  = c;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "tx_pause", tx_pause, 0);
        chk("R1", "st_xoff_sent", st_xoff_sent, 0);
        chk("R1", "tx_ins_req", tx_ins_req, 0);
        chk("R1", "rx_wr", rx_wr, 0);
    endtask

    task automatic t_xoff_send();
        rx_fill = 8'd99;
        step();
        chk("R2", "req below hi", tx_ins_req, 0);
        rx_fill = 8'd100;
        step();
        chk("R2", "req at hi", tx_ins_req, 1);
        chk("R2", "xoff char", tx_ins_char, 8'h13);
        chk("R10", "data blocked by pending insert", tx_data_ok, 0);
        step(); step(); step();
        chk("R3", "req held", tx_ins_req, 1);
        chk("R3", "char held", tx_ins_char, 8'h13);
        do_ack();
        chk("R3", "req dropped", tx_ins_req, 0);
        chk("R3", "xoff sent", st_xoff_sent, 1);
        rx_fill = 8'd127;
        step(); step(); step();
        chk("R4", "no second xoff", tx_ins_req, 0);
    endtask

    task automatic t_xon_send();
        rx_fill = 8'd21;
        step();
        chk("R5", "req above lo", tx_ins_req, 0);
        rx_fill = 8'd20;
        step();
        chk("R5", "req at lo", tx_ins_req, 1);
        chk("R5", "xon char", tx_ins_char, 8'h11);
        do_ack();
        chk("R6", "req dropped", tx_ins_req, 0);
        chk("R6", "xoff cleared", st_xoff_sent, 0);
        rx_fill = 8'd0;
        step(); step();
        chk("R5", "no xon without xoff", tx_ins_req, 0);
    endtask

    task automatic t_full_range();
        cfg_hi_level = 8'd128;
        cfg_lo_level = 8'd0;
        rx_fill = 8'd127;
        step();
        chk("R2", "hi=128 fill 127", tx_ins_req, 0);
        rx_fill = 8'd128;
        step();
        chk("R2", "hi=128 fill 128", tx_ins_req, 1);
        do_ack();
        rx_fill = 8'd1;
        step();
        chk("R5", "lo=0 fill 1", tx_ins_req, 0);
        rx_fill = 8'd0;
        step();
        chk("R5", "lo=0 fill 0", tx_ins_req, 1);
        chk("R5", "lo=0 xon char", tx_ins_char, 8'h11);
        do_ack();
        chk("R6", "full range xoff cleared", st_xoff_sent, 0);
        cfg_hi_level = 8'd100;
        cfg_lo_level = 8'd20;
    endtask

    task automatic t_send_off();
        cfg_send_en = 1'b0;
        rx_fill = 8'd128;
        step(); step(); step();
        chk("R11", "no req when disabled", tx_ins_req, 0);
        chk("R11", "no xoff when disabled", st_xoff_sent, 0);
        rx_fill = 8'd50;
        step();
        cfg_send_en = 1'b1;
        step();
        chk("R11", "mid level after enable", tx_ins_req, 0);
    endtask

    task automatic t_remote();
        send_rx(8'h13);
        chk("R7", "pause set", tx_pause, 1);
        chk("R7", "xoff not stored", rx_wr, 0);
        chk("R10", "data blocked by pause", tx_data_ok, 0);
        send_rx(8'h11);
        chk("R8", "pause cleared", tx_pause, 0);
        chk("R8", "xon not stored", rx_wr, 0);
        chk("R10", "data allowed", tx_data_ok, 1);
        send_rx(8'h41);
        chk("R9", "data stored", rx_wr, 1);
        chk("R9", "data value", rx_wr_char, 8'h41);
        step();
        chk("R9", "single strobe", rx_wr, 0);
    endtask

    task automatic t_obey_off();
        send_rx(8'h13);
        chk("R7", "pause before disable", tx_pause, 1);
        cfg_obey_en = 1'b0;
        step();
        chk("R9", "pause released", tx_pause, 0);
        send_rx(8'h13);
        chk("R9", "xoff stored when off", rx_wr, 1);
        chk("R9", "xoff value stored", rx_wr_char, 8'h13);
        chk("R9", "no pause when off", tx_pause, 0);
        cfg_obey_en = 1'b1;
        step();
    endtask

    task automatic t_cts();
        send_rx(8'h13);
        cts_ok = 1'b0;
        rx_fill = 8'd100;
        step();
        chk("R10", "insert despite pause and cts", tx_ins_req, 1);
        chk("R10", "insert char", tx_ins_char, 8'h13);
        do_ack();
        chk("R10", "still paused", tx_data_ok, 0);
        send_rx(8'h11);
        chk("R10", "blocked by cts", tx_data_ok, 0);
        cts_ok = 1'b1;
        step();
        chk("R10", "released", tx_data_ok, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cfg_send_en   = 1'b1;
        cfg_obey_en   = 1'b1;
        cfg_xon_char  = 8'h11;
        cfg_xoff_char = 8'h13;
        cfg_hi_level  = 8'd100;
        cfg_lo_level  = 8'd20;
        rx_fill       = 8'd0;
        rx_valid      = 1'b0;
        rx_char       = 8'h00;
        tx_ins_ack    = 1'b0;
        cts_ok        = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_xoff_send();
        t_xon_send();
        t_full_range();
        t_send_off();
        t_remote();
        t_obey_off();
        t_cts();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule